// File: doc/BRIEF.md
# DDR2 Refresh Interval Scheduler

This block sits beside the command arbiter of a DDR2 memory controller and decides when an all-bank refresh is owed. A down-counter measures the average refresh interval in controller clock cycles. Each time it expires, one more refresh is owed, and the block asks the arbiter for a refresh slot. The arbiter may postpone refreshes up to a bounded number. When that bound is reached the request is flagged urgent, and the arbiter must serve it ahead of any other command.

When the arbiter grants a refresh, the block opens a recovery window of fixed length. During that window the busy output blocks activates, and no further refresh is requested. A high-temperature input selects an interval of half the normal length, which doubles the refresh rate for hot devices. The flag is sampled only when the interval counter reloads, so a count that is already running is never shortened or stretched.

Top module: `refresh_sched`

## Requirements
- R1: While reset is high, and on the first cycle after it, req_o, urgent_o and busy_o are low. Reset loads the full (cool) interval, so req_o first goes high exactly INTERVAL_CYC cycles after reset is released.
- R2: With hot_i low, one more refresh becomes owed every INTERVAL_CYC cycles.
- R3: With hot_i high at a reload, the next interval lasts INTERVAL_CYC/2 cycles.
- R4: req_o stays high while any refresh is owed and the block is not busy. It stays high until a grant is taken. A grant_i pulse while req_o is low has no effect.
- R5: A grant taken while req_o is high raises busy_o on the next cycle. busy_o then stays high for exactly RECOVERY_CYC cycles, and req_o is low throughout that window.
- R6: grant_i asserted during the recovery window neither extends nor restarts the window.
- R7: Each granted refresh reduces the owed count by exactly one. req_o falls once the count reaches zero.
- R8: The owed count saturates at MAX_OWED. Interval expiries at that count are dropped.
- R9: urgent_o is high exactly when MAX_OWED refreshes are owed and the block is not busy. It falls after one grant.
- R10: A change on hot_i in the middle of an interval does not alter the interval in progress. It takes effect from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| hot_i | input | 1 | High case temperature; selects the halved interval at the next reload |
| grant_i | input | 1 | Arbiter has issued the requested refresh |
| req_o | output | 1 | A refresh is owed and may be issued now |
| urgent_o | output | 1 | The postponement limit is reached; serve before any other command |
| busy_o | output | 1 | Refresh recovery window; activates and refreshes are blocked |

## Verification
The hardest state to reach is saturation of the owed count: the bound hides the lost expiries, and the ports do not report the count. The stimulus withholds grants for two more intervals after urgent_o rises. It then shows that exactly MAX_OWED grants drain the request, with grants held high through each recovery window to show the window does not stretch. Mid-interval temperature changes are placed at known cycle offsets, so that an early or missed reload moves a request edge by a computable number of cycles.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  // Interval length chosen at each reload: halved when the device runs hot.
  function automatic int unsigned reload_len(int unsigned base, logic hot);
    return hot ? (base / 2) : base;
  endfunction

  // Owed-refresh count after one cycle, saturating at the limit.
  function automatic int unsigned owed_step(int unsigned owed, logic tick,
                                            logic take, int unsigned limit);
    int unsigned n;
    n = owed;
    if (tick && n < limit) n = n + 1;
    if (take && n > 0) n = n - 1;
    return n;
  endfunction
endpackage

// File: rtl/interval_timer.sv
module interval_timer
  import refresh_pkg::*;
#(
  parameter int unsigned INTERVAL_CYC = 3120,
  parameter int unsigned CNT_W        = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic hot_i,
  output logic tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= CNT_W'(INTERVAL_CYC - 1);
    else if (tick_o)
      cnt_q <= CNT_W'(reload_len(INTERVAL_CYC, hot_i) - 1);
    else
      cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/owed_counter.sv
module owed_counter
  import refresh_pkg::*;
#(
  parameter int unsigned MAX_OWED = 8,
  parameter int unsigned OWED_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              take_i,
  output logic [OWED_W-1:0] owed_o
);
  logic [OWED_W-1:0] owed_q;

  assign owed_o = owed_q;

  always_ff @(posedge clk) begin
    if (rst)
      owed_q <= '0;
    else
      owed_q <= OWED_W'(owed_step(int'(owed_q), tick_i, take_i, MAX_OWED));
  end
endmodule

// File: rtl/recovery_timer.sv
module recovery_timer #(
  parameter int unsigned RECOVERY_CYC = 51,
  parameter int unsigned REC_W        = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);
  logic [REC_W-1:0] rec_q;

  assign busy_o = (rec_q != '0);

  always_ff @(posedge clk) begin
    if (rst)
      rec_q <= '0;
    else if (start_i)
      rec_q <= REC_W'(RECOVERY_CYC);
    else if (busy_o)
      rec_q <= rec_q - 1'b1;
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned INTERVAL_CYC = 3120,
  parameter int unsigned RECOVERY_CYC = 51,
  parameter int unsigned MAX_OWED     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hot_i,
  input  logic grant_i,
  output logic req_o,
  output logic urgent_o,
  output logic busy_o
);
  localparam int unsigned CNT_W  = $clog2(INTERVAL_CYC);
  localparam int unsigned REC_W  = $clog2(RECOVERY_CYC + 1);
  localparam int unsigned OWED_W = $clog2(MAX_OWED + 1);

  logic              tick;
  logic              take;
  logic              busy;
  logic [OWED_W-1:0] owed_q;

  interval_timer #(.INTERVAL_CYC(INTERVAL_CYC), .CNT_W(CNT_W)) u_interval (
    .clk(clk), .rst(rst), .hot_i(hot_i), .tick_o(tick)
  );

  owed_counter #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) u_owed (
    .clk(clk), .rst(rst), .tick_i(tick), .take_i(take), .owed_o(owed_q)
  );

  recovery_timer #(.RECOVERY_CYC(RECOVERY_CYC), .REC_W(REC_W)) u_recovery (
    .clk(clk), .rst(rst), .start_i(take), .busy_o(busy)
  );

  assign req_o    = (owed_q != '0) && !busy;
  assign urgent_o = req_o && (owed_q == OWED_W'(MAX_OWED));
  assign take     = grant_i && req_o;
  assign busy_o   = busy;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int unsigned RECOVERY_CYC = 51,
  parameter int unsigned MAX_OWED     = 8,
  parameter int unsigned OWED_W       = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              grant_i,
  input logic              req_o,
  input logic              urgent_o,
  input logic              busy_o,
  input logic [OWED_W-1:0] owed_q
);
  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (rst)         busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  a_r5_busy_blocks_req: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !req_o);
  a_r5_grant_starts_busy: assert property (@(posedge clk) disable iff (rst)
    (grant_i && req_o) |=> busy_o);
  a_r5_window_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (busy_len == RECOVERY_CYC));
  a_r6_busy_only_from_grant: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(grant_i && req_o));
  a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
    (req_o && !grant_i) |=> req_o);
  a_r9_urgent_implies_req: assert property (@(posedge clk) disable iff (rst)
    urgent_o |-> req_o);
  a_r8_owed_bound: assert property (@(posedge clk) disable iff (rst)
    int'(owed_q) <= MAX_OWED);
endmodule

bind refresh_sched refresh_sched_chk #(
  .RECOVERY_CYC(RECOVERY_CYC), .MAX_OWED(MAX_OWED), .OWED_W(OWED_W)
) u_chk (
  .clk(clk), .rst(rst), .grant_i(grant_i), .req_o(req_o),
  .urgent_o(urgent_o), .busy_o(busy_o), .owed_q(owed_q)
);

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb;
  localparam int unsigned IV = 32;
  localparam int unsigned RC = 5;
  localparam int unsigned MX = 3;
  localparam int unsigned HIV = IV / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hot_i = 1'b0;
  logic grant_i = 1'b0;
  logic req_o, urgent_o, busy_o;
  int n_checks = 0;
  int n_fail = 0;

  refresh_sched #(.INTERVAL_CYC(IV), .RECOVERY_CYC(RC), .MAX_OWED(MX)) u_dut (
    .clk(clk), .rst(rst), .hot_i(hot_i), .grant_i(grant_i),
    .req_o(req_o), .urgent_o(urgent_o), .busy_o(busy_o)
  );

  always #4 clk = ~clk;

  task automatic chk(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic hot);
    rst = 1'b1;
    hot_i = hot;
    grant_i = 1'b0;
    step(3);
    chk("R1 req in reset", req_o, 1'b0);
    chk("R1 urgent in reset", urgent_o, 1'b0);
    chk("R1 busy in reset", busy_o, 1'b0);
    rst = 1'b0;
  endtask

  task automatic grant_once();
    grant_i = 1'b1;
    step(1);
    grant_i = 1'b0;
  endtask

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // Cool interval, saturation, recovery window
    do_reset(1'b0);
    step(1);
    chk("R1 req just after reset", req_o, 1'b0);
    chk("R1 urgent just after reset", urgent_o, 1'b0);
    chk("R1 busy just after reset", busy_o, 1'b0);
    step(IV - 2);
    chk("R1 req before first interval", req_o, 1'b0);
    step(1);
    chk("R1 req at first interval", req_o, 1'b1);
    chk("R9 urgent with one owed", urgent_o, 1'b0);
    step(MX * IV - IV - 1);
    chk("R2 urgent one cycle before limit", urgent_o, 1'b0);
    step(1);
    chk("R2 urgent at limit", urgent_o, 1'b1);
    step(2 * IV);
    chk("R8 urgent while saturated", urgent_o, 1'b1);
    grant_once();
    chk("R5 busy after grant", busy_o, 1'b1);
    chk("R5 req low in window", req_o, 1'b0);
    chk("R9 urgent low after grant", urgent_o, 1'b0);
    grant_i = 1'b1;
    for (int k = 1; k < RC; k++) begin
      step(1);
      chk("R5 busy held in window", busy_o, 1'b1);
      chk("R5 req low in window", req_o, 1'b0);
    end
    grant_i = 1'b0;
    step(1);
    chk("R6 busy ends on time despite grants", busy_o, 1'b0);
    chk("R7 req after window with owed left", req_o, 1'b1);
    chk("R9 urgent below limit", urgent_o, 1'b0);
    for (int g = 2; g <= int'(MX); g++) begin
      grant_once();
      step(RC);
      chk("R7 busy done", busy_o, 1'b0);
      chk("R8 req after grant", req_o, (g < int'(MX)) ? 1'b1 : 1'b0);
    end
    // now at edge 5*IV + 3*(RC+1); next expiry at 6*IV
    step(6 * IV - (5 * IV + 3 * (RC + 1)) - 1);
    chk("R2 req before next interval", req_o, 1'b0);
    step(1);
    chk("R2 req at next interval", req_o, 1'b1);
    step(40);
    chk("R4 req held without grant", req_o, 1'b1);

    // Grant with nothing owed is ignored
    do_reset(1'b0);
    step(5);
    grant_once();
    chk("R4 stray grant gives no busy", busy_o, 1'b0);
    chk("R4 stray grant gives no req", req_o, 1'b0);
    step(IV - 6 - 1);
    chk("R4 req before interval after stray grant", req_o, 1'b0);
    step(1);
    chk("R4 req on time after stray grant", req_o, 1'b1);

    // Hot from reset: first interval full, later ones halved
    do_reset(1'b1);
    step(IV - 1);
    chk("R3 req before first interval", req_o, 1'b0);
    step(1);
    chk("R3 req at first interval", req_o, 1'b1);
    step(2 * HIV - 1);
    chk("R3 urgent before halved limit", urgent_o, 1'b0);
    step(1);
    chk("R3 urgent at halved limit", urgent_o, 1'b1);

    // Mid-interval temperature changes apply only at reload
    do_reset(1'b0);
    step(HIV);
    hot_i = 1'b1;
    step(IV - HIV - 1);
    chk("R10 req not early after hot rise", req_o, 1'b0);
    step(1);
    chk("R10 req at full interval", req_o, 1'b1);
    step(HIV / 2);
    hot_i = 1'b0;
    step(HIV + IV - HIV / 2 - 1);
    chk("R10 urgent before expected", urgent_o, 1'b0);
    step(1);
    chk("R10 urgent at expected cycle", urgent_o, 1'b1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule